// File: doc/BRIEF.md
# RAM-Programmable Memory Cycle Sequencer

This block generates external memory bus waveforms from a table rather than from fixed state machines. A 64-word by 32-bit pattern RAM holds the waveforms. Software loads it through a simple write port while the block is idle. Each kind of request has a start location of its own. When a request is taken, the sequencer steps through consecutive words, one per clock. Each word it executes is latched onto the chip-select, byte-select and general-purpose output lines for one clock.

Seven request kinds can start a pattern: four access kinds (read or write, single-beat or burst), a refresh timer expiry, a bus-timeout exception and a software run command that names its own start word. Two bits in each word control the sequencing. One marks the last word of a pattern. The other lets an external wait input, brought in through a two-flop synchronizer, hold execution on the current word.

Top module: `mcyc_sequencer`

## Requirements
- R1: After reset, and whenever no pattern is active, `cs_o`, `bs_o` and `gp_o` are all zero and `busy_o` is 0.
- R2: A taken request drives its first word on the outputs two clock edges after the request is sampled. Each later word is driven for exactly one clock. Word bits [3:0] appear on `cs_o`, bits [7:4] on `bs_o` and bits [13:8] on `gp_o`.
- R3: While the executing word has bit 31 (last) clear, the index advances by one each clock. A word with bit 31 set is the final word driven, and the outputs return to zero on the following clock.
- R4: An access request starts at word 0x00 for a single read, 0x08 for a burst read, 0x18 for a single write and 0x20 for a burst write. The kind is selected by `acc_write_i` and `acc_burst_i`.
- R5: An access request is taken only when `op_mode_i` is 2'b00. In any other mode it has no effect.
- R6: A refresh request starts at 0x30 and a timeout request starts at 0x3C. A run command starts at `run_index_i`.
- R7: When requests coincide, the priority order is timeout, then refresh, then access, then run.
- R8: While a pattern is active, refresh, access and run requests are ignored. A timeout request aborts the active pattern and starts the exception pattern.
- R9: When the executing word has bit 30 (wait-enable) set, the index holds on that word for as long as the twice-registered `wait_i` is high. With bit 30 clear, `wait_i` has no effect.
- R10: A write on the RAM port is performed only while no pattern is active. A write issued during a pattern leaves the RAM unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_mode_i | input | 2 | Operation mode; 2'b00 allows access patterns |
| acc_req_i | input | 1 | Access request from a mapped region |
| acc_write_i | input | 1 | Access is a write (0 = read) |
| acc_burst_i | input | 1 | Access is a burst (0 = single beat) |
| refresh_req_i | input | 1 | Refresh timer expiry |
| timeout_req_i | input | 1 | Bus-monitor timeout; starts the exception pattern |
| run_req_i | input | 1 | Software run command |
| run_index_i | input | 6 | Start word for the run command |
| wait_i | input | 1 | Asynchronous external wait |
| cfg_we_i | input | 1 | Pattern RAM write enable |
| cfg_addr_i | input | 6 | Pattern RAM write address |
| cfg_wdata_i | input | 32 | Pattern RAM write data |
| cs_o | output | 4 | Chip-select lines |
| bs_o | output | 4 | Byte-select lines |
| gp_o | output | 6 | General-purpose lines |
| busy_o | output | 1 | A pattern is being indexed |

## Verification
The RAM is filled with computed words whose last bit marks every fourth location. A run command is then issued at each of the 64 indices, which reads back the whole table and shows both the stepping order and the termination. Each request kind is then fired alone and in overlapping sets. These runs separate the start-index selection from the priority order, and they separate mode gating from busy gating. A timeout during a burst shows the abort. The wait input is held high over a wait-enabled word and then over a word without the bit set, which separates a real freeze from a stall that should not occur. The release is checked at the exact clock that follows from the two-flop synchronizer.

// File: rtl/mcyc_pkg.sv
`timescale 1ns/1ps
package mcyc_pkg;
  localparam int IDX_W     = 6;
  localparam int WORD_W    = 32;
  localparam int CS_W      = 4;
  localparam int BS_W      = 4;
  localparam int GP_W      = 6;
  localparam int CS_LSB    = 0;
  localparam int BS_LSB    = CS_LSB + CS_W;
  localparam int GP_LSB    = BS_LSB + BS_W;
  localparam int WAIT_BIT  = 30;
  localparam int LAST_BIT  = 31;

  localparam logic [IDX_W-1:0] START_RD_SINGLE = 6'h00;
  localparam logic [IDX_W-1:0] START_RD_BURST  = 6'h08;
  localparam logic [IDX_W-1:0] START_WR_SINGLE = 6'h18;
  localparam logic [IDX_W-1:0] START_WR_BURST  = 6'h20;
  localparam logic [IDX_W-1:0] START_REFRESH   = 6'h30;
  localparam logic [IDX_W-1:0] START_EXCEPTION = 6'h3C;

  localparam logic [1:0] MODE_NORMAL = 2'b00;

  typedef struct packed {
    logic [GP_W-1:0] gp;
    logic [BS_W-1:0] bs;
    logic [CS_W-1:0] cs;
  } pins_t;

  // Grant vector positions, highest priority first
  localparam int G_EXC = 3;
  localparam int G_REF = 2;
  localparam int G_ACC = 1;
  localparam int G_RUN = 0;

  function automatic pins_t word_pins(input logic [WORD_W-1:0] w);
    pins_t p;
    p.cs = w[CS_LSB +: CS_W];
    p.bs = w[BS_LSB +: BS_W];
    p.gp = w[GP_LSB +: GP_W];
    return p;
  endfunction

  function automatic logic [IDX_W-1:0] access_start(input logic wr, input logic burst);
    case ({wr, burst})
      2'b00:   return START_RD_SINGLE;
      2'b01:   return START_RD_BURST;
      2'b10:   return START_WR_SINGLE;
      default: return START_WR_BURST;
    endcase
  endfunction

  function automatic logic [IDX_W-1:0] next_index(input logic [IDX_W-1:0] i);
    return i + IDX_W'(1);
  endfunction
endpackage

// File: rtl/mcyc_wait_sync.sv
`timescale 1ns/1ps
module mcyc_wait_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic sync_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], async_i};
  end

  assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/mcyc_pattern_ram.sv
`timescale 1ns/1ps
module mcyc_pattern_ram #(
  parameter int IDX_W  = 6,
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_i,
  input  logic [IDX_W-1:0]  waddr_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic [IDX_W-1:0]  raddr_i,
  output logic [WORD_W-1:0] rdata_o
);
  localparam int DEPTH = 1 << IDX_W;

  logic [WORD_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we_i) mem[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem[raddr_i];

  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    we_i |=> mem[$past(waddr_i)] == $past(wdata_i)); // R10
endmodule

// File: rtl/mcyc_arbiter.sv
`timescale 1ns/1ps
module mcyc_arbiter
  import mcyc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             busy_i,
  input  logic [1:0]       op_mode_i,
  input  logic             acc_req_i,
  input  logic             acc_write_i,
  input  logic             acc_burst_i,
  input  logic             refresh_req_i,
  input  logic             timeout_req_i,
  input  logic             run_req_i,
  input  logic [IDX_W-1:0] run_index_i,
  output logic             start_o,
  output logic [IDX_W-1:0] start_idx_o,
  output logic [3:0]       grant_o
);
  logic acc_ok;

  assign acc_ok = acc_req_i && (op_mode_i == MODE_NORMAL);

  always_comb begin
    grant_o        = '0;
    grant_o[G_EXC] = timeout_req_i;
    grant_o[G_REF] = !busy_i && !timeout_req_i && refresh_req_i;
    grant_o[G_ACC] = !busy_i && !timeout_req_i && !refresh_req_i && acc_ok;
    grant_o[G_RUN] = !busy_i && !timeout_req_i && !refresh_req_i && !acc_ok && run_req_i;
  end

  always_comb begin
    start_idx_o = run_index_i;
    if (grant_o[G_EXC])      start_idx_o = START_EXCEPTION;
    else if (grant_o[G_REF]) start_idx_o = START_REFRESH;
    else if (grant_o[G_ACC]) start_idx_o = access_start(acc_write_i, acc_burst_i);
  end

  assign start_o = |grant_o;

  AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_o)); // R7
  AST_BUSY_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_i && !timeout_req_i) |-> !start_o); // R8
  AST_MODE_GATES: assert property (@(posedge clk) disable iff (!rst_n)
    (op_mode_i != MODE_NORMAL) |-> !grant_o[G_ACC]); // R5
endmodule

// File: rtl/mcyc_sequencer.sv
`timescale 1ns/1ps
module mcyc_sequencer
  import mcyc_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        op_mode_i,
  input  logic              acc_req_i,
  input  logic              acc_write_i,
  input  logic              acc_burst_i,
  input  logic              refresh_req_i,
  input  logic              timeout_req_i,
  input  logic              run_req_i,
  input  logic [IDX_W-1:0]  run_index_i,
  input  logic              wait_i,
  input  logic              cfg_we_i,
  input  logic [IDX_W-1:0]  cfg_addr_i,
  input  logic [WORD_W-1:0] cfg_wdata_i,
  output logic [CS_W-1:0]   cs_o,
  output logic [BS_W-1:0]   bs_o,
  output logic [GP_W-1:0]   gp_o,
  output logic              busy_o
);
  logic              run_q;
  logic [IDX_W-1:0]  idx_q;
  pins_t             pins_q;
  logic [WORD_W-1:0] cur_word;
  logic              wait_sync;
  logic              start_take;
  logic [IDX_W-1:0]  start_idx;
  logic [3:0]        grant;
  logic              ram_we;
  logic              word_waits;
  logic              word_last;
  logic              freeze;
  logic              step;

  mcyc_arbiter u_arb (
    .clk           (clk),
    .rst_n         (rst_n),
    .busy_i        (run_q),
    .op_mode_i     (op_mode_i),
    .acc_req_i     (acc_req_i),
    .acc_write_i   (acc_write_i),
    .acc_burst_i   (acc_burst_i),
    .refresh_req_i (refresh_req_i),
    .timeout_req_i (timeout_req_i),
    .run_req_i     (run_req_i),
    .run_index_i   (run_index_i),
    .start_o       (start_take),
    .start_idx_o   (start_idx),
    .grant_o       (grant)
  );

  mcyc_wait_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (wait_i),
    .sync_o  (wait_sync)
  );

  assign ram_we = cfg_we_i && !run_q;

  mcyc_pattern_ram #(.IDX_W(IDX_W), .WORD_W(WORD_W)) u_ram (
    .clk     (clk),
    .rst_n   (rst_n),
    .we_i    (ram_we),
    .waddr_i (cfg_addr_i),
    .wdata_i (cfg_wdata_i),
    .raddr_i (idx_q),
    .rdata_o (cur_word)
  );

  // Named per-word events for the checks below
  assign word_waits = cur_word[WAIT_BIT];
  assign word_last  = cur_word[LAST_BIT];
  assign freeze     = run_q && word_waits && wait_sync;
  assign step       = run_q && !freeze && !start_take;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      idx_q  <= '0;
      pins_q <= '0;
    end else begin
      pins_q <= run_q ? word_pins(cur_word) : '0;
      if (start_take) begin
        run_q <= 1'b1;
        idx_q <= start_idx;
      end else if (step) begin
        if (word_last) run_q <= 1'b0;
        else           idx_q <= next_index(idx_q);
      end
    end
  end

  assign cs_o   = pins_q.cs;
  assign bs_o   = pins_q.bs;
  assign gp_o   = pins_q.gp;
  assign busy_o = run_q;

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q |=> (pins_q == '0)); // R1
  AST_STEP_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !word_last) |=> (run_q && idx_q == next_index($past(idx_q)))); // R3
  AST_LAST_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    (step && word_last) |=> !run_q); // R3
  AST_FREEZE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (freeze && !timeout_req_i) |=> (run_q && $stable(idx_q))); // R9
  AST_EXC_ABORTS: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_req_i |=> (run_q && idx_q == START_EXCEPTION)); // R8
  AST_WORD_SHOWN: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |=> (pins_q == word_pins($past(cur_word)))); // R2
endmodule

// File: tb/mcyc_sequencer_tb.sv
`timescale 1ns/1ps
module mcyc_sequencer_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  op_mode = 2'b00;
  logic        acc_req = 1'b0, acc_write = 1'b0, acc_burst = 1'b0;
  logic        refresh_req = 1'b0, timeout_req = 1'b0, run_req = 1'b0;
  logic [5:0]  run_index = '0;
  logic        wait_in = 1'b0;
  logic        cfg_we = 1'b0;
  logic [5:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [3:0]  cs;
  logic [3:0]  bs;
  logic [5:0]  gp;
  logic        busy;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #4 clk = ~clk; // 125 MHz

  mcyc_sequencer u_dut (
    .clk(clk), .rst_n(rst_n), .op_mode_i(op_mode),
    .acc_req_i(acc_req), .acc_write_i(acc_write), .acc_burst_i(acc_burst),
    .refresh_req_i(refresh_req), .timeout_req_i(timeout_req), .run_req_i(run_req),
    .run_index_i(run_index), .wait_i(wait_in),
    .cfg_we_i(cfg_we), .cfg_addr_i(cfg_addr), .cfg_wdata_i(cfg_wdata),
    .cs_o(cs), .bs_o(bs), .gp_o(gp), .busy_o(busy)
  );

  // Table content: last bit on every fourth word, wait-enable on word 0x31
  function automatic logic [31:0] exp_word(input int a);
    logic [13:0] p;
    logic lst, wen;
    p   = 14'((a * 29 + 11) ^ (a << 7));
    lst = (a % 4) == 3;
    wen = (a == 49);
    return {lst, wen, 16'h0000, p};
  endfunction

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic expect_word(input string req, input int a);
    logic [31:0] w;
    w = exp_word(a);
    check(req, {18'h0, gp, bs, cs}, {18'h0, w[13:8], w[7:4], w[3:0]});
  endtask

  task automatic expect_idle(input string req);
    check(req, {27'h0, busy, gp, bs, cs}, 32'h0);
  endtask

  // Samples from the next negedge on: start, start+1, ... up to a last word, then idle
  task automatic follow(input string req, input int start);
    int a;
    a = start;
    forever begin
      tick();
      expect_word(req, a);
      if ((a % 4) == 3) break;
      a++;
    end
    tick();
    expect_idle(req);
  endtask

  task automatic clear_reqs();
    acc_req = 0; refresh_req = 0; timeout_req = 0; run_req = 0;
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    expect_idle("R1 reset");
    rst_n = 1;
    tick();
    expect_idle("R1 after reset");

    // Load the table while idle
    for (int a = 0; a < 64; a++) begin
      cfg_we = 1; cfg_addr = 6'(a); cfg_wdata = exp_word(a);
      tick();
    end
    cfg_we = 0;
    tick();
    expect_idle("R1 idle after load");

    // R2 R3 R6 R10: run command at every index reads the table back
    for (int a = 0; a < 64; a++) begin
      run_index = 6'(a); run_req = 1;
      tick();
      run_req = 0;
      follow("R2 R3 R6 run sweep", a);
    end

    // R4: access start indices; wait held high with no wait-enable word (R9)
    wait_in = 1;
    for (int k = 0; k < 4; k++) begin
      int st;
      st = (k == 0) ? 'h00 : (k == 1) ? 'h08 : (k == 2) ? 'h18 : 'h20;
      acc_write = k[1]; acc_burst = k[0]; acc_req = 1;
      tick();
      acc_req = 0;
      follow("R4 R9 access start, wait ignored", st);
    end
    wait_in = 0;
    repeat (3) tick();

    // R6: refresh and exception starts
    refresh_req = 1; tick(); clear_reqs();
    follow("R6 refresh start", 'h30);
    timeout_req = 1; tick(); clear_reqs();
    follow("R6 exception start", 'h3C);

    // R7: priority
    acc_write = 0; acc_burst = 1; run_index = 6'h05;
    timeout_req = 1; refresh_req = 1; acc_req = 1; run_req = 1;
    tick(); clear_reqs();
    follow("R7 timeout wins", 'h3C);
    refresh_req = 1; acc_req = 1; run_req = 1;
    tick(); clear_reqs();
    follow("R7 refresh over access", 'h30);
    acc_req = 1; run_req = 1;
    tick(); clear_reqs();
    follow("R7 access over run", 'h08);

    // R5: access in non-normal modes has no effect; run still taken
    op_mode = 2'b01; acc_req = 1;
    tick(); clear_reqs();
    tick(); expect_idle("R5 mode 01 access ignored");
    tick(); expect_idle("R5 mode 01 access ignored");
    op_mode = 2'b10; acc_req = 1;
    tick(); clear_reqs();
    tick(); expect_idle("R5 mode 10 access ignored");
    op_mode = 2'b01; acc_req = 1; run_req = 1; run_index = 6'h05;
    tick(); clear_reqs();
    follow("R5 run taken when access gated", 5);
    op_mode = 2'b00;

    // R8: requests ignored while busy
    acc_write = 0; acc_burst = 1; acc_req = 1;
    tick(); clear_reqs();
    refresh_req = 1; run_req = 1; run_index = 6'h10;
    tick(); expect_word("R8 busy ignores", 'h08);
    tick(); expect_word("R8 busy ignores", 'h09);
    clear_reqs();
    follow("R8 busy ignores", 'h0A);

    // R8: timeout aborts a burst write
    acc_write = 1; acc_burst = 1; acc_req = 1;
    tick(); clear_reqs();
    tick(); expect_word("R8 abort", 'h20);
    timeout_req = 1;
    tick(); expect_word("R8 abort", 'h21);
    clear_reqs();
    follow("R8 abort to exception", 'h3C);

    // R10: write during a pattern is dropped
    run_index = 6'h3C; run_req = 1;
    tick(); clear_reqs();
    cfg_we = 1; cfg_addr = 6'h00; cfg_wdata = ~exp_word(0);
    tick(); expect_word("R10", 'h3C);
    cfg_we = 0;
    follow("R10", 'h3D);
    acc_write = 0; acc_burst = 0; acc_req = 1;
    tick(); clear_reqs();
    follow("R10 word 0 unchanged", 0);

    // R9: freeze on wait-enabled word 0x31
    wait_in = 1;
    repeat (3) tick();
    refresh_req = 1; tick(); clear_reqs();
    tick(); expect_word("R9 freeze", 'h30);
    for (int i = 0; i < 6; i++) begin
      tick(); expect_word("R9 freeze holds", 'h31);
    end
    wait_in = 0;
    for (int i = 0; i < 3; i++) begin
      tick(); expect_word("R9 release latency", 'h31);
    end
    follow("R9 resumes", 'h32);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule